// File: doc/BRIEF.md
# Vector Horizontal Widening Add/Subtract Unit

This block is one datapath slice of a 128-bit SIMD unit. It takes two source vectors and builds a result vector of widened elements. Each result element takes one narrow element from each source: the odd-numbered narrow element of source A and the even-numbered narrow element of source B. Both are extended to the result width first, and then they are added, or the B element is subtracted from the A element. Four result widths are available: 16, 32, 64 and the full 128 bits. Sign or zero extension is chosen per operation. Results wrap at the result width, with no saturation and no flags.

The unit sits behind instruction decode and register read. It takes a single beat qualified by `in_valid`. With the default `REG_OUT = 1`, the result comes from an output register one cycle later, flagged by `out_valid`. With `REG_OUT = 0`, the path is purely combinational and `out_valid` follows `in_valid`. The vector width is a parameter. It must be a power-of-two multiple of 128 bits, and each 128-bit lane behaves the same way.

Top module: `hwa_unit`

## Requirements
- R1: With `size_sel = 0`, result bits [16i+15:16i] (i = 0..7) combine A bits [16i+15:16i+8] with B bits [16i+7:16i], each taken as an 8-bit element.
- R2: With `size_sel = 1`, result bits [32i+31:32i] (i = 0..3) combine A bits [32i+31:32i+16] with B bits [32i+15:32i].
- R3: With `size_sel = 2`, result bits [64i+63:64i] (i = 0..1) combine A bits [64i+63:64i+32] with B bits [64i+31:64i].
- R4: With `size_sel = 3`, the full 128-bit result combines A bits [127:64] with B bits [63:0].
- R5: With `op_signed = 1`, both narrow elements are sign-extended to the result width before the operation.
- R6: With `op_signed = 0`, both narrow elements are zero-extended to the result width before the operation.
- R7: With `op_sub = 0`, the result is A-element plus B-element. With `op_sub = 1`, it is A-element minus B-element. Subtraction works in both signedness modes.
- R8: Results wrap modulo 2^width. For example, an unsigned subtract in mode 0 with A byte 1 = 0x00 and B byte 0 = 0xFF gives result element 0 = 0xFF01.
- R9: With `REG_OUT = 1`, a beat accepted while `in_valid` is high shows its result on `result` with `out_valid` high on the following clock edge.
- R10: With `REG_OUT = 1`, a cycle with `in_valid` low drives `out_valid` low on the next edge and leaves `result` unchanged, whatever the other inputs do.
- R11: While `rst_n` is low, `out_valid` is 0 and `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies the operands and controls of this cycle |
| src_a | input | VEC_W | First source; its odd narrow elements are used |
| src_b | input | VEC_W | Second source; its even narrow elements are used |
| op_sub | input | 1 | 0 = add, 1 = subtract (A minus B) |
| op_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| size_sel | input | 2 | Result width: 0 = 16, 1 = 32, 2 = 64, 3 = 128 bits |
| out_valid | output | 1 | Result is valid |
| result | output | VEC_W | Widened result vector |

## Verification
The operands include zero, all-ones, and the most-negative and most-positive value of each narrow width, replicated across the vector. These show whether sign extension or zero extension was applied, and whether a subtract borrows into the widened upper half. Random operands at every width, in every sign mode and for both operations, would expose a wrong element pairing: swapping odd and even, or reading the wrong source, gives visibly different lanes. Idle cycles carry random inputs to show that the held result is never disturbed.

// File: rtl/hwa_pkg.sv
package hwa_pkg;

   localparam int unsigned LANE_W     = 128;
   localparam int unsigned MIN_RES_W  = 16;
   localparam int unsigned NUM_SIZES  = 4;
   localparam int unsigned SIZE_SEL_W = 2;

   typedef enum logic [SIZE_SEL_W-1:0] {
      SZ_HALF   = 2'd0,
      SZ_WORD   = 2'd1,
      SZ_DOUBLE = 2'd2,
      SZ_QUAD   = 2'd3
   } hwa_size_e;

   function automatic int unsigned res_width(input int unsigned sz);
      return MIN_RES_W << sz;
   endfunction

endpackage

// File: rtl/hwa_elem.sv
module hwa_elem #(
   parameter int unsigned RES_W = 16
) (
   input  logic [RES_W/2-1:0] odd_a,
   input  logic [RES_W/2-1:0] even_b,
   input  logic               is_sub,
   input  logic               is_signed,
   output logic [RES_W-1:0]   res
);
   localparam int unsigned HALF_W = RES_W / 2;

   if (RES_W < 4 || (RES_W % 2) != 0) begin : g_bad_width
      $error("hwa_elem: RES_W must be even and at least 4");
   end

   logic [RES_W-1:0] ext_a;
   logic [RES_W-1:0] ext_b;

   assign ext_a = {{HALF_W{is_signed & odd_a[HALF_W-1]}}, odd_a};
   assign ext_b = {{HALF_W{is_signed & even_b[HALF_W-1]}}, even_b};

   always_comb begin
      if (is_sub) res = ext_a - ext_b;
      else        res = ext_a + ext_b;
   end

   always_comb begin
      if (!$isunknown({odd_a, even_b, is_sub, is_signed})) begin
         // R5: half-width signed operands never reach the sign bit of the result
         if (is_signed) begin
            a_r5_signed_fits: assert (res[RES_W-1] == res[RES_W-2]);
         end
         // R6: unsigned sum of two narrow values leaves the top bit clear
         if (!is_signed && !is_sub) begin
            a_r6_unsigned_add_fits: assert (res[RES_W-1] == 1'b0);
         end
         // R8: unsigned difference sets the top bit exactly when it borrowed
         if (!is_signed && is_sub) begin
            a_r8_unsigned_sub_wrap: assert (res[RES_W-1] == (odd_a < even_b));
         end
      end
   end

endmodule

// File: rtl/hwa_width_slice.sv
module hwa_width_slice #(
   parameter int unsigned VEC_W = 128,
   parameter int unsigned RES_W = 16
) (
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             is_sub,
   input  logic             is_signed,
   output logic [VEC_W-1:0] res_vec
);
   localparam int unsigned HALF_W  = RES_W / 2;
   localparam int unsigned N_ELEMS = VEC_W / RES_W;

   if ((VEC_W % RES_W) != 0) begin : g_bad_split
      $error("hwa_width_slice: VEC_W must be a multiple of RES_W");
   end

   logic [N_ELEMS-1:0] unused_halves;

   for (genvar i = 0; i < N_ELEMS; i++) begin : g_elem
      localparam int unsigned LO = i * RES_W;

      hwa_elem #(.RES_W(RES_W)) u_elem (
         .odd_a     (src_a[LO+RES_W-1 -: HALF_W]),
         .even_b    (src_b[LO+HALF_W-1 -: HALF_W]),
         .is_sub    (is_sub),
         .is_signed (is_signed),
         .res       (res_vec[LO+RES_W-1 -: RES_W])
      );

      assign unused_halves[i] = ^{src_a[LO+HALF_W-1 -: HALF_W],
                                  src_b[LO+RES_W-1 -: HALF_W]};
   end

endmodule

// File: rtl/hwa_out_stage.sv
module hwa_out_stage #(
   parameter int unsigned DATA_W  = 128,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
         end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= in_data;
         end
      end

      // R9: an accepted beat is flagged on the next edge with its data
      a_r9_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (out_valid && out_data == $past(in_data)));

      // R10: an idle cycle drops the flag and keeps the data
      a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(out_data)));

      // R9: the flag only rises after an accepted beat
      a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(out_valid) |-> $past(in_valid));
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign out_data   = in_data;
   end

endmodule

// File: rtl/hwa_unit.sv
module hwa_unit #(
   parameter int unsigned VEC_W   = 128,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic             op_sub,
   input  logic             op_signed,
   input  logic [1:0]       size_sel,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   import hwa_pkg::*;

   localparam int unsigned N_LANES = VEC_W / LANE_W;

   if (VEC_W < LANE_W || (VEC_W % LANE_W) != 0 || (N_LANES & (N_LANES - 1)) != 0) begin : g_bad_vec
      $error("hwa_unit: VEC_W must be a power-of-two multiple of 128");
   end

   logic [VEC_W-1:0] slice_res [NUM_SIZES];
   logic [VEC_W-1:0] comb_res;

   for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
      hwa_width_slice #(
         .VEC_W (VEC_W),
         .RES_W (res_width(k))
      ) u_slice (
         .src_a     (src_a),
         .src_b     (src_b),
         .is_sub    (op_sub),
         .is_signed (op_signed),
         .res_vec   (slice_res[k])
      );
   end

   always_comb begin
      unique case (hwa_size_e'(size_sel))
         SZ_HALF:   comb_res = slice_res[0];
         SZ_WORD:   comb_res = slice_res[1];
         SZ_DOUBLE: comb_res = slice_res[2];
         default:   comb_res = slice_res[3];
      endcase
   end

   hwa_out_stage #(
      .DATA_W  (VEC_W),
      .REG_OUT (REG_OUT)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (comb_res),
      .out_valid (out_valid),
      .out_data  (result)
   );

endmodule

// File: tb/test_hwa_unit.sv
module test_hwa_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src_a = '0;
   logic [127:0] src_b = '0;
   logic         op_sub = 1'b0;
   logic         op_signed = 1'b0;
   logic [1:0]   size_sel = 2'd0;
   logic         out_valid;
   logic [127:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [127:0] last_res = '0;

   always #2 clk = ~clk;

   hwa_unit #(.VEC_W(128), .REG_OUT(1'b1)) i_hwa_unit (
      .clk, .rst_n, .in_valid, .src_a, .src_b, .op_sub, .op_signed,
      .size_sel, .out_valid, .result
   );

   function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                          input bit sub, input bit sgn, input int sz);
      int ew = 16 << sz;
      int hw = ew / 2;
      logic [255:0] mh, me, xa, xb, r;
      logic [127:0] acc = '0;
      mh = (256'd1 << hw) - 256'd1;
      me = (256'd1 << ew) - 256'd1;
      for (int i = 0; i < 128 / ew; i++) begin
         xa = ({128'd0, a} >> ((2 * i + 1) * hw)) & mh;
         xb = ({128'd0, b} >> ((2 * i) * hw)) & mh;
         if (sgn && xa[hw-1]) xa = xa | ~mh;
         if (sgn && xb[hw-1]) xb = xb | ~mh;
         r = sub ? xa - xb : xa + xb;
         acc = acc | 128'((r & me) << (i * ew));
      end
      return acc;
   endfunction

   function automatic string tag_of(input bit sub, input bit sgn, input int sz);
      string s;
      case (sz)
         0: s = "R1";
         1: s = "R2";
         2: s = "R3";
         default: s = "R4";
      endcase
      s = {s, sgn ? "/R5" : "/R6", sub ? "/R7" : ""};
      return s;
   endfunction

   task automatic check_val(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // one clock: drive at falling edge, compare shortly after the rising edge
   task automatic step(input logic [127:0] a, input logic [127:0] b, input bit sub,
                       input bit sgn, input int sz, input bit vld, input string req);
      logic [127:0] exp;
      @(negedge clk);
      src_a = a; src_b = b; op_sub = sub; op_signed = sgn;
      size_sel = 2'(sz); in_valid = vld;
      exp = vld ? model(a, b, sub, sgn, sz) : last_res;
      @(posedge clk);
      #1;
      check_val({req, "/R9/R10 valid"}, {127'd0, out_valid}, {127'd0, vld});
      check_val(req, result, exp);
      last_res = exp;
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   logic [127:0] corner [10];

   initial begin
      corner[0] = '0;
      corner[1] = '1;
      corner[2] = {16{8'h80}};
      corner[3] = {8{16'h8000}};
      corner[4] = {4{32'h8000_0000}};
      corner[5] = {2{64'h8000_0000_0000_0000}};
      corner[6] = {16{8'h7f}};
      corner[7] = {2{64'h7fff_ffff_ffff_ffff}};
      corner[8] = {16{8'h01}};
      corner[9] = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;

      // R11: reset state, even with a beat presented
      in_valid = 1'b1; src_a = '1; src_b = '1;
      repeat (3) @(posedge clk);
      #1;
      check_val("R11 out_valid", {127'd0, out_valid}, 128'd0);
      check_val("R11 result", result, 128'd0);
      @(negedge clk);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_val("R11 after release", result, 128'd0);

      // R8: directed wrap example
      step(128'h0000, 128'h00ff, 1'b1, 1'b0, 0, 1'b1, "R8 direct");
      check_val("R8 element0", {112'd0, result[15:0]}, {112'd0, 16'hff01});

      // R10: idle cycle with random inputs keeps the result
      step(rnd128(), rnd128(), 1'b0, 1'b1, 2, 1'b0, "R10 idle");

      // corner operands in every mode
      for (int sz = 0; sz < 4; sz++)
         for (int m = 0; m < 4; m++)
            for (int x = 0; x < 10; x++)
               for (int y = 0; y < 10; y += 3)
                  step(corner[x], corner[y], m[0], m[1], sz, 1'b1, tag_of(m[0], m[1], sz));

      // random operands with occasional idle cycles
      for (int n = 0; n < 600; n++) begin
         automatic int sz = int'($urandom_range(0, 3));
         automatic bit sub = 1'($urandom);
         automatic bit sgn = 1'($urandom);
         automatic bit vld = ($urandom_range(0, 4) != 0);
         step(rnd128(), rnd128(), sub, sgn, sz, vld,
              vld ? tag_of(sub, sgn, sz) : "R10 idle");
      end

      // back-to-back beats then a hold
      step('1, 128'd0, 1'b1, 1'b1, 3, 1'b1, "R4/R5/R7 q");
      step(128'd0, '1, 1'b1, 1'b0, 3, 1'b1, "R4/R6/R7/R8 q");
      step(rnd128(), rnd128(), 1'b1, 1'b1, 1, 1'b0, "R10 hold");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R9: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule